// File: doc/BRIEF.md
# USB Endpoint Interrupt Status Register

This block collects event strobes and condition flags from the endpoint logic of a USB function core. It latches each one into a bit of a 16-bit interrupt status register, so the CPU can see which condition raised its interrupt. Each of the four IN endpoints and each of the four OUT endpoints has its own bit. One further bit is shared by all error conditions. A single interrupt request line, the OR of all status bits, goes to the CPU.

An IN endpoint bit is set for any of three reasons:
- the endpoint becomes enabled;
- a data set has been sent;
- a flush happens while its double buffer is occupied. The flush may be automatic or commanded by the CPU.

Each IN endpoint tracks its enable with a two-state machine:
- States: `EP_DISABLED` and `EP_ENABLED`.
- Transitions: `ENABLE` (enable seen high in `EP_DISABLED`) and `DISABLE` (enable seen low in `EP_ENABLED`).
- Only the `ENABLE` transition produces a status event.

An OUT endpoint bit is set when a data set has been received. The error bit is set on the rising edge of any of the error flags.

The CPU clears bits by writing 1 to them. The read data is always the current register value.

Top module: `usb_ep_irq_status`

## Requirements
- R1: After reset, `reg_rdata` is 0x0000 and `irq` is 0.
- R2: Bit 2k (k = 0..3 for IN endpoints 1..4) sets when `in_en[k]` is high and the endpoint's state machine is in `EP_DISABLED`. If `in_en[k]` stays high, the bit is not set again.
- R3: A one-cycle pulse on `in_tx_done[k]` sets bit 2k.
- R4: A pulse on `in_auto_flush[k]` or `in_cpu_flush[k]` sets bit 2k only when the occupancy field `in_occ[2k+1:2k]` is 1 or 2. With occupancy 0, nothing is set.
- R5: A pulse on `out_rx_done[k]` sets bit 2k+1.
- R6: Bit 8 sets on the rising edge of any of the error flags. The flags are `ctl_stall`, `ctl_setup_end`, any `in_underrun[k]`, any `out_overrun[k]` and any `out_stall[k]`. A flag held high produces one event only.
- R7: A write (`reg_wr` high) clears each bit whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R8: A set event in the same cycle as a clear of that bit leaves the bit at 1.
- R9: `irq` is 1 exactly when any status bit is 1. Bits 15..9 always read 0.

Every event takes effect at the clock edge that samples it, so it is visible in `reg_rdata` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_en | input | 4 | IN endpoint enable levels |
| in_tx_done | input | 4 | IN data set sent strobes |
| in_auto_flush | input | 4 | IN hardware flush strobes |
| in_cpu_flush | input | 4 | IN CPU flush command strobes |
| in_occ | input | 8 | IN buffer occupancy, 2 bits per endpoint (0..2) |
| out_rx_done | input | 4 | OUT data set received strobes |
| ctl_stall | input | 1 | Control endpoint force-stall flag |
| ctl_setup_end | input | 1 | Control endpoint setup-end flag |
| in_underrun | input | 4 | IN underrun flags |
| out_overrun | input | 4 | OUT overrun flags |
| out_stall | input | 4 | OUT force-stall flags |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data, 1 clears a bit |
| reg_rdata | output | 16 | Status register value |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
- **Enable state machine:** if it stuck in `EP_DISABLED`, a held enable would set its bit again one cycle after every CPU clear. If it stuck in `EP_ENABLED`, a fresh enable would leave its bit at 0 in the cycle after the edge.
- **Error-flag history:** if it were lost, clearing bit 8 while a flag stays high would show the bit back at 1 one cycle later.
- **Clear-versus-set priority:** an error here shows as a lost event in the very next read.
- Every stimulus is therefore compared one cycle after its sampling edge.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    typedef enum logic {
        EP_DISABLED = 1'b0,
        EP_ENABLED  = 1'b1
    } ep_state_t;

    localparam int OCC_W = 2;
endpackage

// File: rtl/in_ep_evt.sv
module in_ep_evt
    import usb_irq_pkg::*;
#(
    parameter int OCC_W_P = OCC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tx_done,
    input  logic             auto_flush,
    input  logic             cpu_flush,
    input  logic [OCC_W_P-1:0] occ,
    output logic             evt
);
    ep_state_t state_q, state_d;
    logic      enable_evt;
    logic      flush_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EP_DISABLED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        enable_evt = 1'b0;
        unique case (state_q)
            EP_DISABLED: if (en) begin
                state_d    = EP_ENABLED;
                enable_evt = 1'b1;
            end
            EP_ENABLED: if (!en) state_d = EP_DISABLED;
            default: state_d = EP_DISABLED;
        endcase
    end

    always_comb begin
        flush_evt = (auto_flush || cpu_flush) &&
                    (occ == OCC_W_P'(1) || occ == OCC_W_P'(2));
        evt = enable_evt || tx_done || flush_evt;
    end

    a_r2_enable_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EP_DISABLED && en) |=> (state_q == EP_ENABLED));

    a_r2_held_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EP_ENABLED && !tx_done && !auto_flush && !cpu_flush) |-> !evt);

    a_r4_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0 && state_q == EP_ENABLED && !tx_done) |-> !evt);
endmodule

// File: rtl/err_agg.sv
module err_agg #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] srcs,
    output logic             evt
);
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= srcs;
    end

    always_comb evt = |(srcs & ~prev_q);

    a_r6_held_once: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> (!$stable(srcs) || !evt));
endmodule

// File: rtl/status_reg.sv
module status_reg #(
    parameter int REG_W  = 16,
    parameter int USED_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [USED_W-1:0] set,
    input  logic              wr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  q
);
    logic [USED_W-1:0] stat_q, clr;

    always_comb clr = wr ? wdata[USED_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | set;
    end

    always_comb q = {{(REG_W-USED_W){1'b0}}, stat_q};

    for (genvar i = 0; i < USED_W; i++) begin : g_chk
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wdata[i] && !set[i]) |=> !q[i]);
        a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !(wr && wdata[i])) |=> q[i]);
        a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);
    end
endmodule

// File: rtl/usb_ep_irq_status.sv
module usb_ep_irq_status
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 4,
    parameter int REG_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EP-1:0]       in_en,
    input  logic [NUM_EP-1:0]       in_tx_done,
    input  logic [NUM_EP-1:0]       in_auto_flush,
    input  logic [NUM_EP-1:0]       in_cpu_flush,
    input  logic [NUM_EP*OCC_W-1:0] in_occ,
    input  logic [NUM_EP-1:0]       out_rx_done,
    input  logic                    ctl_stall,
    input  logic                    ctl_setup_end,
    input  logic [NUM_EP-1:0]       in_underrun,
    input  logic [NUM_EP-1:0]       out_overrun,
    input  logic [NUM_EP-1:0]       out_stall,
    input  logic                    reg_wr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    output logic                    irq
);
    localparam int USED_W  = 2 * NUM_EP + 1;
    localparam int ERR_BIT = 2 * NUM_EP;
    localparam int N_ERR   = 2 + 3 * NUM_EP;

    logic [USED_W-1:0] set;
    logic [N_ERR-1:0]  err_srcs;
    logic              err_evt;

    for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
        in_ep_evt #(.OCC_W_P(OCC_W)) u_in (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (in_en[k]),
            .tx_done    (in_tx_done[k]),
            .auto_flush (in_auto_flush[k]),
            .cpu_flush  (in_cpu_flush[k]),
            .occ        (in_occ[k*OCC_W +: OCC_W]),
            .evt        (set[2*k])
        );
        always_comb set[2*k+1] = out_rx_done[k];
    end

    always_comb err_srcs = {out_stall, out_overrun, in_underrun, ctl_setup_end, ctl_stall};

    err_agg #(.N_SRC(N_ERR)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .srcs  (err_srcs),
        .evt   (err_evt)
    );

    always_comb set[ERR_BIT] = err_evt;

    status_reg #(.REG_W(REG_W), .USED_W(USED_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .q     (reg_rdata)
    );

    always_comb irq = |reg_rdata;

    a_r9_irq_rises_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> irq);
endmodule

// File: tb/tb_usb_ep_irq_status.sv
module tb_usb_ep_irq_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_en = '0, in_tx_done = '0, in_auto_flush = '0, in_cpu_flush = '0;
    logic [7:0]  in_occ = '0;
    logic [3:0]  out_rx_done = '0, in_underrun = '0, out_overrun = '0, out_stall = '0;
    logic        ctl_stall = 1'b0, ctl_setup_end = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    logic [15:0] m_stat = '0;
    logic [3:0]  m_en_prev = '0;
    logic [13:0] m_err_prev = '0;

    always #4 clk = ~clk;

    usb_ep_irq_status dut (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_tx_done(in_tx_done),
        .in_auto_flush(in_auto_flush), .in_cpu_flush(in_cpu_flush), .in_occ(in_occ),
        .out_rx_done(out_rx_done), .ctl_stall(ctl_stall), .ctl_setup_end(ctl_setup_end),
        .in_underrun(in_underrun), .out_overrun(out_overrun), .out_stall(out_stall),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // Monitor: compares one cycle after each sampling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (reg_rdata !== it.exp) begin
                failures++;
                $display("FAIL %s: rdata=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
            checks++;
            if (irq !== (it.exp != 0)) begin
                failures++;
                $display("FAIL R9 (%s): irq=%b expected=%b", it.tag, irq, it.exp != 0);
            end
        end
    end

    // Driver: one clock of stimulus, model update, push expectation
    task automatic cyc(string tag);
        logic [15:0] setv;
        logic [13:0] errv;
        item_t it;
        @(posedge clk);
        setv = '0;
        errv = {out_stall, out_overrun, in_underrun, ctl_setup_end, ctl_stall};
        for (int k = 0; k < 4; k++) begin
            logic [1:0] oc;
            oc = in_occ[2*k +: 2];
            if ((in_en[k] && !m_en_prev[k]) || in_tx_done[k] ||
                ((in_auto_flush[k] || in_cpu_flush[k]) && (oc == 2'd1 || oc == 2'd2)))
                setv[2*k] = 1'b1;
            if (out_rx_done[k]) setv[2*k+1] = 1'b1;
        end
        if (|(errv & ~m_err_prev)) setv[8] = 1'b1;
        m_stat = ((m_stat & ~(reg_wr ? reg_wdata : 16'h0)) | setv) & 16'h01FF;
        m_en_prev = in_en;
        m_err_prev = errv;
        it.exp = m_stat;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        in_tx_done = '0; in_auto_flush = '0; in_cpu_flush = '0;
        out_rx_done = '0; reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic wclr(logic [15:0] v, string tag);
        reg_wr = 1'b1;
        reg_wdata = v;
        cyc(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc("R1 reset state");

        in_en[0] = 1'b1; cyc("R2 enable edge ep1");
        wclr(16'h0001, "R7 clear bit0");
        cyc("R2 held enable no repeat");
        in_en[2] = 1'b1; cyc("R2 enable edge ep3");
        wclr(16'hFFFF, "R7 clear all");

        in_tx_done[1] = 1'b1; cyc("R3 tx done ep2");
        wclr(16'h0004, "R7 clear bit2");

        in_occ[7:6] = 2'd0; in_cpu_flush[3] = 1'b1; cyc("R4 empty flush ignored");
        in_occ[7:6] = 2'd1; in_auto_flush[3] = 1'b1; cyc("R4 autoflush occ1");
        wclr(16'h0040, "R7 clear bit6");
        in_occ[1:0] = 2'd2; in_cpu_flush[0] = 1'b1; cyc("R4 cpu flush occ2");

        out_rx_done[3] = 1'b1; cyc("R5 rx ep4");
        out_rx_done[0] = 1'b1; cyc("R5 rx ep1");
        wclr(16'h0000, "R7 write zero no effect");
        wclr(16'hFE00, "R9 upper bits write");
        wclr(16'hFFFF, "R7 clear all again");

        ctl_stall = 1'b1; cyc("R6 ctl stall rise");
        wclr(16'h0100, "R6 clear err");
        cyc("R6 held flag no repeat");
        in_underrun[2] = 1'b1; cyc("R6 underrun rise");
        wclr(16'h0100, "R6 clear err 2");
        out_overrun[1] = 1'b1; cyc("R6 overrun rise");
        wclr(16'h0100, "R6 clear err 3");
        out_stall[3] = 1'b1; cyc("R6 out stall rise");
        wclr(16'h0100, "R6 clear err 4");
        ctl_setup_end = 1'b1; cyc("R6 setup end rise");
        ctl_stall = 1'b0; cyc("R6 fall no event");
        ctl_stall = 1'b1; cyc("R6 re-rise sets");

        wclr(16'hFFFF, "R7 clear before R8");
        out_rx_done[1] = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0008;
        cyc("R8 set beats clear");
        in_tx_done[0] = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0009;
        cyc("R8 set beats clear, other bit cleared");

        in_en = '0; cyc("R2 disable");
        in_en[0] = 1'b1; cyc("R2 re-enable edge");
        wclr(16'hFFFF, "R9 irq drops");
        cyc("R9 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule